// File: doc/BRIEF.md
# Byte-Level I2C Master Controller

This block is a single-master I2C controller that software runs one byte at a time through four 8-bit registers: control, status, data and own address. Software puts the target address in the data register and writes a master mode together with the start and enable bits. The controller then produces a START and shifts the address out. After each byte and its acknowledge cycle it raises a pending flag and holds SCL low. Nothing moves on the bus until software clears that flag, so each byte boundary is a handshake that stretches the clock.

While the flag is pending, software can load the next byte, ask for a STOP, or ask for a repeated START and change direction. In receive mode it can also choose whether the master answers the next byte with ACK or NACK. The SCL rate comes from a coarse prescaler (divide by 16 or by 512) followed by a 4-bit divisor. The pads are open drain: each output pulls its line low when asserted, and SDA is read back through a two-stage synchronizer.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and neither `scl_oe` nor `sda_oe` is asserted.
- R2: Registers are selected by `wr_sel`/`rd_sel`: 0 = control, 1 = status, 2 = data, 3 = own address. Control bits are: 7 ACK enable, 6 prescaler select, 5 interrupt enable, 4 pending flag, 3:0 divisor. Software cannot set the pending flag. `irq` equals pending AND interrupt enable. The own-address register reads back the value last written.
- R3: One SCL period lasts P*(divisor+1) clock cycles, where P is 16 when control bit 6 is 0 and 512 when it is 1. A new divisor takes effect on the byte that follows the write.
- R4: Status bits are: 7:6 mode (11 = master transmit, 10 = master receive), 5 busy when read and start/stop when written, 4 transmit/receive enable, 0 last ACK bit. With the bus idle, a status write with bits 7, 5 and 4 set produces a START and then sends the data register MSB first as the address byte.
- R5: After the ninth SCL pulse of a byte the pending flag sets and SCL stays low. A control write with bit 4 = 0 clears the flag and releases the bus. A control write with bit 4 = 1 leaves the flag and the bus unchanged.
- R6: Status bit 0 holds the SDA level sampled on the ninth SCL pulse of the last byte: 0 = ACK, 1 = NACK.
- R7: A status write with bit 5 = 0 while busy causes a STOP once the pending flag is cleared. Busy then reads 0 and both lines are released.
- R8: A status write with bit 5 = 1 while busy causes a repeated START, with no STOP, once the pending flag is cleared. The data register is then sent as a new address byte, and the mode written at the same time takes effect.
- R9: In master receive mode, data bytes are read MSB first and the received byte is in the data register when the pending flag sets. The master drives ACK (SDA low) on the ninth pulse when control bit 7 is 1, and leaves SDA high (NACK) when it is 0.
- R10: A data register write is ignored while a byte is on the bus (busy and not pending).
- R11: SDA changes while SCL is high only to form a START or a STOP.
- R12: Busy reads 1 from the status write that starts a transfer until the STOP completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register written |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register read |
| rd_data | output | 8 | Read data (combinational) |
| irq | output | 1 | Byte-complete interrupt |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA line level |

## Verification
If the sequencer loses its position in a byte, the fault shows at the pads within one SCL period. A wrong phase moves an SDA edge into the SCL-high window, where it reads as a false START or STOP. A wrong bit count shifts every later byte and acknowledge slot. If the pending flag and the bus state disagree, SCL toggles while the interrupt is raised, which the bench compares on every clock. An address or ACK that is wrongly latched shows up at the next status or data read as a bit 0 or byte value that differs from the one the bench slave drove.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    E_IDLE,
    E_COND,
    E_BIT,
    E_HOLD,
    E_STOP
  } eng_state_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_OWN  = 2'd3;

  localparam logic [1:0] MODE_MTX = 2'b11;
  localparam logic [1:0] MODE_MRX = 2'b10;

  localparam int DIV_W = 4;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int PRE_SMALL = 16,
  parameter int PRE_LARGE = 512,
  parameter int DIV_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_sel,
  input  logic [DIV_W-1:0] div,
  output logic             qtick
);
  localparam int QS    = PRE_SMALL / 4;
  localparam int QL    = PRE_LARGE / 4;
  localparam int CNT_W = $clog2(QL * (1 << DIV_W)) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, base, lim;

  always_comb begin
    base = pre_sel ? CNT_W'(QL) : CNT_W'(QS);
    lim  = base * (CNT_W'(div) + CNT_W'(1)) - CNT_W'(1);
  end

  assign qtick = run && (cnt_q == lim);

  always_comb begin
    if (!run)        cnt_d = '0;
    else if (qtick)  cnt_d = '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       qtick,
  input  logic       cmd_start,
  input  logic       cmd_go,
  input  logic       stop_req,
  input  logic       rs_req,
  input  logic       rx_mode,
  input  logic       ack_en,
  input  logic [7:0] tx_byte,
  input  logic       sda_in,
  output logic       run,
  output logic       busy,
  output logic       in_cond,
  output logic       byte_done,
  output logic       rx_load,
  output logic [7:0] rx_byte,
  output logic       nack,
  output logic       scl_low,
  output logic       sda_low
);
  eng_state_t st_q, st_d;
  logic [1:0] ph_q, ph_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       first_q, first_d;
  logic       nack_q, nack_d;
  logic       scl_q, scl_d;
  logic       sda_q, sda_d;
  logic       rcv;

  assign rcv       = rx_mode && !first_q;
  assign run       = (st_q == E_COND) || (st_q == E_BIT) || (st_q == E_STOP);
  assign busy      = (st_q != E_IDLE);
  assign in_cond   = (st_q == E_COND) || (st_q == E_STOP);
  assign byte_done = (st_q == E_BIT) && qtick && (ph_q == 2'd3) && (bit_q == 4'd8);
  assign rx_load   = byte_done && rcv;
  assign rx_byte   = sh_q;
  assign nack      = nack_q;
  assign scl_low   = scl_q;
  assign sda_low   = sda_q;

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    first_d = first_q;
    nack_d  = nack_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    case (st_q)
      E_IDLE: begin
        if (cmd_start) begin
          st_d = E_COND;
          ph_d = 2'd0;
          sh_d = tx_byte;
        end
      end
      E_COND: begin
        if (qtick) begin
          ph_d = ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_d = 1'b0;
            2'd1: scl_d = 1'b0;
            2'd2: sda_d = 1'b1;
            default: begin
              scl_d   = 1'b1;
              st_d    = E_BIT;
              bit_d   = 4'd0;
              first_d = 1'b1;
            end
          endcase
        end
      end
      E_BIT: begin
        if (qtick) begin
          ph_d = ph_q + 2'd1;
          case (ph_q)
            2'd0: begin
              if (bit_q == 4'd8) sda_d = rcv ? ack_en : 1'b0;
              else               sda_d = rcv ? 1'b0 : !sh_q[7];
            end
            2'd1: scl_d = 1'b0;
            2'd2: begin
              if (bit_q == 4'd8) nack_d = sda_in;
              else               sh_d   = {sh_q[6:0], sda_in};
            end
            default: begin
              scl_d = 1'b1;
              if (bit_q == 4'd8) st_d = E_HOLD;
              else               bit_d = bit_q + 4'd1;
            end
          endcase
        end
      end
      E_HOLD: begin
        if (cmd_go) begin
          ph_d = 2'd0;
          if (stop_req) begin
            st_d = E_STOP;
          end else if (rs_req) begin
            st_d = E_COND;
            sh_d = tx_byte;
          end else begin
            st_d    = E_BIT;
            bit_d   = 4'd0;
            sh_d    = tx_byte;
            first_d = 1'b0;
          end
        end
      end
      E_STOP: begin
        if (qtick) begin
          ph_d = ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_d = 1'b1;
            2'd1: scl_d = 1'b0;
            2'd2: sda_d = 1'b0;
            default: st_d = E_IDLE;
          endcase
        end
      end
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= E_IDLE;
      ph_q    <= 2'd0;
      bit_q   <= 4'd0;
      sh_q    <= 8'd0;
      first_q <= 1'b0;
      nack_q  <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      first_q <= first_d;
      nack_q  <= nack_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int PRE_SMALL = 16,
  parameter int PRE_LARGE = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_sel,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  logic             ack_en_q, ack_en_d;
  logic             pre_q, pre_d;
  logic             int_en_q, int_en_d;
  logic             pend_q, pend_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [1:0]       mode_q, mode_d;
  logic             txrx_q, txrx_d;
  logic [7:0]       data_q, data_d;
  logic [7:0]       own_q, own_d;
  logic             stop_q, stop_d;
  logic             rs_q, rs_d;
  logic             sda_s1_q, sda_s2_q;

  logic       qtick, run, busy, in_cond, byte_done, rx_load, nack;
  logic [7:0] rx_byte;
  logic       wr_ctrl, wr_stat, wr_data_s, wr_own, go, cmd_start;

  assign wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);
  assign wr_stat   = wr_en && (wr_sel == SEL_STAT);
  assign wr_data_s = wr_en && (wr_sel == SEL_DATA);
  assign wr_own    = wr_en && (wr_sel == SEL_OWN);
  assign go        = wr_ctrl && !wr_data[4] && pend_q;
  assign cmd_start = wr_stat && !busy && wr_data[7] && wr_data[5] && wr_data[4];

  i2cm_tick #(
    .PRE_SMALL(PRE_SMALL),
    .PRE_LARGE(PRE_LARGE),
    .DIV_W    (DIV_W)
  ) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .pre_sel(pre_q),
    .div    (div_q),
    .qtick  (qtick)
  );

  i2cm_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .qtick    (qtick),
    .cmd_start(cmd_start),
    .cmd_go   (go),
    .stop_req (stop_q),
    .rs_req   (rs_q),
    .rx_mode  (mode_q == MODE_MRX),
    .ack_en   (ack_en_q),
    .tx_byte  (data_q),
    .sda_in   (sda_s2_q),
    .run      (run),
    .busy     (busy),
    .in_cond  (in_cond),
    .byte_done(byte_done),
    .rx_load  (rx_load),
    .rx_byte  (rx_byte),
    .nack     (nack),
    .scl_low  (scl_oe),
    .sda_low  (sda_oe)
  );

  always_comb begin
    ack_en_d = ack_en_q;
    pre_d    = pre_q;
    int_en_d = int_en_q;
    div_d    = div_q;
    mode_d   = mode_q;
    txrx_d   = txrx_q;
    data_d   = data_q;
    own_d    = own_q;
    stop_d   = stop_q;
    rs_d     = rs_q;
    pend_d   = pend_q;
    if (wr_ctrl) begin
      ack_en_d = wr_data[7];
      pre_d    = wr_data[6];
      int_en_d = wr_data[5];
      div_d    = wr_data[DIV_W-1:0];
    end
    if (byte_done)  pend_d = 1'b1;
    else if (go)    pend_d = 1'b0;
    if (wr_stat) begin
      mode_d = wr_data[7:6];
      txrx_d = wr_data[4];
      if (busy) begin
        rs_d   = wr_data[5];
        stop_d = !wr_data[5];
      end
    end
    if (go) begin
      rs_d   = 1'b0;
      stop_d = 1'b0;
    end
    if (rx_load)                           data_d = rx_byte;
    else if (wr_data_s && (pend_q || !busy)) data_d = wr_data;
    if (wr_own) own_d = wr_data;
  end

  always_comb begin
    case (rd_sel)
      SEL_CTRL: rd_data = {ack_en_q, pre_q, int_en_q, pend_q, div_q};
      SEL_STAT: rd_data = {mode_q, busy, txrx_q, 3'b000, nack};
      SEL_DATA: rd_data = data_q;
      default:  rd_data = own_q;
    endcase
  end

  assign irq = pend_q && int_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_en_q <= 1'b0;
      pre_q    <= 1'b0;
      int_en_q <= 1'b0;
      pend_q   <= 1'b0;
      div_q    <= '0;
      mode_q   <= 2'b00;
      txrx_q   <= 1'b0;
      data_q   <= 8'd0;
      own_q    <= 8'd0;
      stop_q   <= 1'b0;
      rs_q     <= 1'b0;
      sda_s1_q <= 1'b1;
      sda_s2_q <= 1'b1;
    end else begin
      ack_en_q <= ack_en_d;
      pre_q    <= pre_d;
      int_en_q <= int_en_d;
      pend_q   <= pend_d;
      div_q    <= div_d;
      mode_q   <= mode_d;
      txrx_q   <= txrx_d;
      data_q   <= data_d;
      own_q    <= own_d;
      stop_q   <= stop_d;
      rs_q     <= rs_d;
      sda_s1_q <= sda_in;
      sda_s2_q <= sda_s1_q;
    end
  end
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pend,
  input logic       busy,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       in_cond,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic       rx_load,
  input logic [7:0] data_q
);
  // R5: a pending byte keeps the clock line pulled low
  a_r5_hold_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> scl_oe);

  // R11: with SCL high across two cycles, SDA may move only inside a START/STOP sequence
  a_r11_sda_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_cond && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

  // R12 and R7: once idle, both lines are released
  a_r12_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  // R10: a data write during an in-flight byte leaves the data register unchanged
  a_r10_data_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && busy && !pend && !rx_load) |=> $stable(data_q));
endmodule

bind i2c_byte_master i2cm_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .pend   (pend_q),
  .busy   (busy),
  .scl_oe (scl_oe),
  .sda_oe (sda_oe),
  .in_cond(in_cond),
  .wr_en  (wr_en),
  .wr_sel (wr_sel),
  .rx_load(rx_load),
  .data_q (data_q)
);

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_sel = 2'd1;
  logic [7:0] rd_data;
  logic       irq, scl_oe, sda_oe;
  logic       slv_low = 1'b0;
  logic       sda_bus;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // bus-level reference: pads, START/STOP events, bytes seen, a simple target device
  int        starts = 0, stops = 0;
  int        bitcnt = 0;
  int        last_rise = 0, last_per = 0;
  logic [7:0] sh = 8'd0;
  logic [8:0] seen[$];
  logic      scl_p = 1'b1, sda_p = 1'b1, scl_b, sda_b;
  bit        addr_ph = 0, slv_sel = 0, slv_rd = 0, slv_tx = 0;
  int        tx_idx = 0;
  localparam logic [6:0] SLV = 7'h50;
  logic [7:0] txb[2];

  assign sda_bus = ~(sda_oe | slv_low);

  always #5 clk = ~clk;

  i2c_byte_master u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_in(sda_bus)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    scl_b = ~scl_oe;
    sda_b = sda_bus;
    if (rst_n) begin
      if (scl_b && scl_p && sda_p && !sda_b) begin
        starts++; bitcnt = 0; addr_ph = 1; slv_tx = 0;
      end else if (scl_b && scl_p && !sda_p && sda_b) begin
        stops++; addr_ph = 0; slv_sel = 0; slv_tx = 0;
      end
      if (scl_b && !scl_p) begin
        if (bitcnt > 0) last_per = cyc - last_rise;
        last_rise = cyc;
        if (bitcnt < 8) sh = {sh[6:0], sda_b};
        bitcnt++;
        if (bitcnt == 9) begin
          seen.push_back({sh, sda_b});
          if (addr_ph) begin
            slv_sel = (sh[7:1] == SLV); slv_rd = sh[0]; addr_ph = 0;
            slv_tx = slv_sel && slv_rd; tx_idx = 0;
          end else if (slv_tx) begin
            if (sda_b) slv_tx = 0; else tx_idx++;
          end
          bitcnt = 0;
        end
      end
      if (!scl_b && scl_p) begin
        if (bitcnt == 8)
          slv_low <= addr_ph ? (sh[7:1] == SLV) : (slv_sel && !slv_rd);
        else if (slv_tx && bitcnt < 8 && tx_idx < 2)
          slv_low <= !txb[tx_idx][7-bitcnt];
        else
          slv_low <= 1'b0;
      end
      // R5 compared on every clock: a raised interrupt means SCL is held low
      if (irq) chk("R5 scl held while pending", scl_oe, 1);
    end
    scl_p = scl_b;
    sda_p = sda_b;
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    rd_sel = s;
    #1 v = rd_data;
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    rd(2'd1, v);
    while (v[5]) rd(2'd1, v);
  endtask

  task automatic exp_byte(input string req, input logic [7:0] b, input logic a);
    logic [8:0] v;
    if (seen.size() == 0) begin
      chk({req, " byte missing"}, 0, 1);
    end else begin
      v = seen.pop_front();
      chk(req, v, {b, a});
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  initial begin
    logic [7:0] v;
    int s0, p0;
    txb[0] = 8'h96; txb[1] = 8'h3B;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 status", v, 0);
    rd(2'd2, v); chk("R1 data", v, 0);
    rd(2'd3, v); chk("R1 own", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    // R2 field readback; bit 4 cannot be set by software
    wr(2'd0, 8'hF5); rd(2'd0, v); chk("R2 ctrl readback", v, 8'hE5);
    wr(2'd3, 8'h3C); rd(2'd3, v); chk("R2 own address", v, 8'h3C);
    wr(2'd0, 8'hA0);

    // R4 write transfer: address 0xA0 to a present target
    wr(2'd2, 8'hA0);
    wr(2'd1, 8'hF0);
    rd(2'd1, v); chk("R12 busy after start", v[5], 1);
    wait_irq();
    chk("R4 one START", starts, 1);
    exp_byte("R4 address byte", 8'hA0, 1'b0);
    rd(2'd1, v); chk("R6 status ack", v, 8'hF0);
    chk("R3 scl period p16 d0", last_per, 16);
    // R5 a write with bit 4 = 1 keeps the flag; R2 irq follows int enable
    wr(2'd0, 8'h90); chk("R2 irq masked", irq, 0);
    rd(2'd0, v); chk("R2 pending visible", v[4], 1);
    wr(2'd0, 8'hB0); chk("R5 bit4=1 keeps pending", irq, 1);
    repeat (40) @(negedge clk);
    chk("R5 no byte while held", seen.size(), 0);
    wr(2'd2, 8'h5A);
    wr(2'd0, 8'hA0);
    wr(2'd2, 8'hFF);  // byte on the bus: must be ignored
    wait_irq();
    rd(2'd2, v); chk("R10 data write ignored in flight", v, 8'h5A);
    exp_byte("R4 data byte sent MSB first", 8'h5A, 1'b0);
    wr(2'd2, 8'hC3);
    wr(2'd0, 8'hA0);
    wait_irq();
    exp_byte("R4 second data byte", 8'hC3, 1'b0);
    wr(2'd1, 8'hD0);
    rd(2'd1, v); chk("R12 busy until stop", v[5], 1);
    wr(2'd0, 8'hA0);
    wait_idle();
    chk("R7 stop seen", stops, 1);
    chk("R11 no stray start", starts, 1);
    rd(2'd1, v); chk("R7 status idle", v, 8'hD0);
    chk("R7 lines released", {scl_oe, sda_oe}, 0);

    // R6 absent target answers NACK
    wr(2'd2, 8'h44);
    wr(2'd1, 8'hF0);
    wait_irq();
    exp_byte("R6 nack on bus", 8'h44, 1'b1);
    rd(2'd1, v); chk("R6 status nack", v[0], 1);
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'hA0);
    wait_idle();
    chk("R7 stop after nack", stops, 2);

    // R8/R9 register read: write pointer, repeated START, two received bytes
    wr(2'd2, 8'hA0);
    wr(2'd1, 8'hF0);
    wait_irq();
    exp_byte("R8 addr write phase", 8'hA0, 1'b0);
    wr(2'd2, 8'h07);
    wr(2'd0, 8'hA0);
    wait_irq();
    exp_byte("R8 pointer byte", 8'h07, 1'b0);
    s0 = starts;
    wr(2'd2, 8'hA1);
    wr(2'd1, 8'hB0);
    wr(2'd0, 8'hA0);
    wait_irq();
    chk("R8 repeated start", starts, s0 + 1);
    chk("R8 no stop before restart", stops, 2);
    exp_byte("R8 read address", 8'hA1, 1'b0);
    rd(2'd1, v); chk("R8 status master receive", v, 8'hB0);
    wr(2'd0, 8'hA0);
    wait_irq();
    rd(2'd2, v); chk("R9 first byte in data reg", v, 8'h96);
    exp_byte("R9 master drives ack", 8'h96, 1'b0);
    wr(2'd0, 8'h30);
    chk("R5 ack change keeps pending", irq, 1);
    wr(2'd0, 8'h20);
    wait_irq();
    rd(2'd2, v); chk("R9 last byte in data reg", v, 8'h3B);
    exp_byte("R9 master leaves nack", 8'h3B, 1'b1);
    wr(2'd1, 8'h90);
    wr(2'd0, 8'h20);
    wait_idle();
    chk("R7 stop after read", stops, 3);

    // R3 prescaler 512 with divisor 1, then divisor change mid transfer
    wr(2'd0, 8'hE1);
    wr(2'd2, 8'hA0);
    wr(2'd1, 8'hF0);
    wait_irq();
    p0 = last_per;
    chk("R3 scl period p512 d1", p0, 1024);
    exp_byte("R3 byte at slow rate", 8'hA0, 1'b0);
    wr(2'd2, 8'h11);
    wr(2'd0, 8'hA3);
    wait_irq();
    chk("R3 scl period p16 d3", last_per, 64);
    exp_byte("R3 byte at new rate", 8'h11, 1'b0);
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'hA3);
    wait_idle();
    chk("R7 final stop", stops, 4);
    chk("R11 start count", starts, 5);
    done = 1;
    finish_run();
  end
endmodule